// File: doc/BRIEF.md
# Conversion Start and Channel Scan Sequencer

This block decides when an analog-to-digital converter runs and which input channel it samples next. It keeps a single start flag that software, a pulse from a PWM unit at its counter centre point, or an external start pin can raise. It also takes a channel-enable mask and a two-bit operating mode. While the flag is up, it hands the converter one channel at a time through a request/done handshake.

Three modes are provided. In single mode only the lowest-numbered enabled channel is sampled. Single-pass scan walks the enabled channels once, upward. Looping scan repeats that walk until software clears the flag. In the two non-looping modes the flag drops by itself once the work is done. The busy output always equals the start flag, so software can poll it.

Top module: `adc_scan_seq`

## Requirements
- R1: The start flag can only be raised while `conv_en` is 1. With `conv_en` at 0 the flag reads 0 one cycle later, and `conv_req` also reads 0 one cycle later.
- R2: Any of these sets the start flag at the next clock edge while `conv_en` is 1: a software write (`sw_wr`=1 with `sw_start`=1), a one-cycle `trig_pwm` pulse, or a one-cycle `trig_pin` pulse. `busy` equals the start flag.
- R3: A software write of 0 (`sw_wr`=1, `sw_start`=0) clears the start flag at the next edge.
- R4: Mode 0 is single mode. Exactly one conversion is made, of the lowest-numbered enabled channel. The flag clears at the edge where `conv_done` is accepted.
- R5: Mode 1 is single-pass scan. Enabled channels are converted in ascending order, one per `conv_done`. The flag clears at the edge that accepts the done of the highest enabled channel.
- R6: Modes 2 and 3 are looping scan. After the highest enabled channel the sequencer wraps to the lowest one, and it continues until the flag is cleared.
- R7: Clearing the flag while a conversion is outstanding keeps `conv_req` high until that conversion's `conv_done`. No further request is then made.
- R8: An empty mask with the flag set behaves by mode. In modes 0 and 1 the flag clears one cycle later and no request is made. In looping modes the flag stays set and no request is made.
- R9: While `conv_req` is high and `conv_done` is low, `conv_req` stays high and `conv_ch` holds its value. Bit n of `chan_mask` selects channel n, and `conv_ch` carries the binary channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Converter enable; must be 1 for any conversion |
| sw_wr | input | 1 | Software write strobe for the start flag |
| sw_start | input | 1 | Value written to the start flag by `sw_wr` |
| trig_pwm | input | 1 | PWM centre-point start pulse |
| trig_pin | input | 1 | External start pin pulse (already synchronised) |
| mode | input | 2 | 0 single, 1 single-pass scan, 2/3 looping scan |
| chan_mask | input | 8 | Channel-enable mask, bit n = channel n |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_req | output | 1 | Conversion request, held until done |
| conv_ch | output | 3 | Channel to convert |
| busy | output | 1 | Mirror of the start flag |

## Verification
On every cycle the assertions check four things. Enable low forces the flag and the request low. A software clear and a trigger act on the flag at the next edge. The channel holds still during an outstanding request. A single-mode done is followed by no request, and a single-pass scan only ever steps to a higher channel. Other behaviour can only be seen in the bench scenarios: the exact channel order for a given mask, the wrap and repeat of looping scan, the completion of a conversion after a mid-flight clear, and the different outcomes of an empty mask in each mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_SINGLE    = 2'd0,
    SEQ_SCAN_ONCE = 2'd1,
    SEQ_SCAN_LOOP = 2'd2,
    SEQ_SCAN_ALT  = 2'd3
  } seq_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

  // looping modes keep the start flag after a full pass
  function automatic logic mode_loops(input logic [1:0] m);
    return m[1];
  endfunction

  // any mode other than single walks the mask
  function automatic logic mode_scans(input logic [1:0] m);
    return (m != SEQ_SINGLE);
  endfunction

endpackage

// File: rtl/adc_chan_pick.sv
// Finds the lowest enabled channel whose index is at or above floor_idx.
module adc_chan_pick #(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW = CW + 1
) (
  input  logic [NCH-1:0] mask,
  input  logic [FW-1:0]  floor_idx,
  output logic           hit,
  output logic [CW-1:0]  idx
);

  logic [NCH-1:0] elig;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = mask[g] && (FW'(g) >= floor_idx);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = CW'(i);
      end
    end
  end

endmodule

// File: rtl/adc_start_ctrl.sv
// Holds the start flag: set by software or a hardware trigger,
// cleared by software, by the sequencer, or by a low enable.
module adc_start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_en,
  input  logic sw_wr,
  input  logic sw_start,
  input  logic trig_pwm,
  input  logic trig_pin,
  input  logic hw_clr,
  output logic start_q
);

  logic any_trig;
  logic start_d;
  logic start_upd;

  assign any_trig  = trig_pwm | trig_pin;
  assign start_upd = !conv_en | sw_wr | hw_clr | any_trig;

  always_comb begin
    if (!conv_en)     start_d = 1'b0;
    else if (sw_wr)   start_d = sw_start;
    else if (hw_clr)  start_d = 1'b0;
    else if (any_trig) start_d = 1'b1;
    else              start_d = start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         start_q <= 1'b0;
    else if (start_upd) start_q <= start_d;
  end

  a_r1_en_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !start_q);

  a_r3_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && sw_wr && !sw_start) |=> !start_q);

  a_r2_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && !sw_wr && !hw_clr && (trig_pwm || trig_pin)) |=> start_q);

endmodule

// File: rtl/adc_scan_fsm.sv
// Issues one conversion request at a time and picks the next channel.
module adc_scan_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_en,
  input  logic          start_q,
  input  logic [1:0]    mode,
  input  logic          first_hit,
  input  logic [CW-1:0] first_idx,
  input  logic          next_hit,
  input  logic [CW-1:0] next_idx,
  input  logic          conv_done,
  output logic          conv_req,
  output logic [CW-1:0] conv_ch,
  output logic          hw_clr
);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] ch_q, ch_d;
  logic          loops, scans, fsm_upd;

  assign loops   = mode_loops(mode);
  assign scans   = mode_scans(mode);
  assign fsm_upd = (state_q == ST_IDLE) | !conv_en | conv_done;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    hw_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_q && conv_en) begin
          if (first_hit) begin
            state_d = ST_WAIT;
            ch_d    = first_idx;
          end else if (!loops) begin
            hw_clr = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!conv_en) begin
          state_d = ST_IDLE;
        end else if (conv_done) begin
          if (!start_q) begin
            state_d = ST_IDLE;
          end else if (!scans) begin
            state_d = ST_IDLE;
            hw_clr  = 1'b1;
          end else if (next_hit) begin
            ch_d = next_idx;
          end else if (loops && first_hit) begin
            ch_d = first_idx;
          end else begin
            state_d = ST_IDLE;
            hw_clr  = !loops;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else if (fsm_upd) begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  assign conv_req = (state_q == ST_WAIT);
  assign conv_ch  = ch_q;

  a_r4_single_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && conv_en && mode == SEQ_SINGLE) |=> !conv_req);

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && conv_en && start_q && mode == SEQ_SCAN_ONCE)
      |=> (!conv_req || conv_ch > $past(conv_ch)));

  a_r7_no_req_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done && !start_q) |=> !conv_req);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW = CW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_en,
  input  logic           sw_wr,
  input  logic           sw_start,
  input  logic           trig_pwm,
  input  logic           trig_pin,
  input  logic [1:0]     mode,
  input  logic [NCH-1:0] chan_mask,
  input  logic           conv_done,
  output logic           conv_req,
  output logic [CW-1:0]  conv_ch,
  output logic           busy
);

  logic          start_q, hw_clr;
  logic          first_hit, next_hit;
  logic [CW-1:0] first_idx, next_idx;
  logic [FW-1:0] next_floor;

  assign next_floor = FW'(conv_ch) + FW'(1);

  adc_start_ctrl u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_en  (conv_en),
    .sw_wr    (sw_wr),
    .sw_start (sw_start),
    .trig_pwm (trig_pwm),
    .trig_pin (trig_pin),
    .hw_clr   (hw_clr),
    .start_q  (start_q)
  );

  adc_chan_pick #(.NCH(NCH)) u_pick_first (
    .mask      (chan_mask),
    .floor_idx ('0),
    .hit       (first_hit),
    .idx       (first_idx)
  );

  adc_chan_pick #(.NCH(NCH)) u_pick_next (
    .mask      (chan_mask),
    .floor_idx (next_floor),
    .hit       (next_hit),
    .idx       (next_idx)
  );

  adc_scan_fsm #(.NCH(NCH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_en   (conv_en),
    .start_q   (start_q),
    .mode      (mode),
    .first_hit (first_hit),
    .first_idx (first_idx),
    .next_hit  (next_hit),
    .next_idx  (next_idx),
    .conv_done (conv_done),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .hw_clr    (hw_clr)
  );

  assign busy = start_q;

  a_r1_en_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !conv_req);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && conv_en) |=> (conv_req && $stable(conv_ch)));

  a_r8_empty_once_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_req && chan_mask == '0 && !mode[1] && conv_en &&
     !sw_wr && !trig_pwm && !trig_pin) |=> !busy);

endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

  localparam int LAT = 3;

  logic       clk, rst_n;
  logic       conv_en, sw_wr, sw_start, trig_pwm, trig_pin;
  logic [1:0] mode;
  logic [7:0] chan_mask;
  logic       conv_done;
  logic       conv_req;
  logic [2:0] conv_ch;
  logic       busy;

  int total = 0;
  int bad   = 0;
  bit model_on;
  int lat_cnt;
  int log_n;
  logic [2:0] log_ch [64];

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .sw_wr(sw_wr),
    .sw_start(sw_start), .trig_pwm(trig_pwm), .trig_pin(trig_pin),
    .mode(mode), .chan_mask(chan_mask), .conv_done(conv_done),
    .conv_req(conv_req), .conv_ch(conv_ch), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // converter model: done pulse LAT cycles after a request is seen
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_done = 1'b0;
      lat_cnt   = 0;
    end else if (conv_done) begin
      conv_done = 1'b0;
      lat_cnt   = 0;
    end else if (conv_req && model_on) begin
      if (lat_cnt == LAT - 1) begin
        conv_done = 1'b1;
        if (log_n < 64) log_ch[log_n] = conv_ch;
        log_n++;
      end else begin
        lat_cnt++;
      end
    end else if (!conv_req) begin
      lat_cnt = 0;
    end
  end

  // {mode, mask, source, count, expected channels as nibbles}
  localparam logic [47:0] VEC [8] = '{
    {2'd0, 8'hB4, 2'd0, 4'd1, 32'h0000_0002},
    {2'd1, 8'hB4, 2'd1, 4'd4, 32'h0000_7542},
    {2'd1, 8'h01, 2'd2, 4'd1, 32'h0000_0000},
    {2'd1, 8'h80, 2'd0, 4'd1, 32'h0000_0007},
    {2'd0, 8'hFF, 2'd2, 4'd1, 32'h0000_0000},
    {2'd1, 8'hFF, 2'd0, 4'd8, 32'h7654_3210},
    {2'd0, 8'h80, 2'd1, 4'd1, 32'h0000_0007},
    {2'd1, 8'h00, 2'd0, 4'd0, 32'h0000_0000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fire(input int src);
    @(negedge clk);
    case (src)
      0: begin sw_wr = 1'b1; sw_start = 1'b1; end
      1: trig_pwm = 1'b1;
      default: trig_pin = 1'b1;
    endcase
    @(negedge clk);
    sw_wr = 1'b0; sw_start = 1'b0; trig_pwm = 1'b0; trig_pin = 1'b0;
  endtask

  task automatic sw_clear();
    @(negedge clk);
    sw_wr = 1'b1; sw_start = 1'b0;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500 && (busy || conv_req); k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; conv_en = 1'b1; sw_wr = 1'b0; sw_start = 1'b0;
    trig_pwm = 1'b0; trig_pin = 1'b0; mode = 2'd0; chan_mask = 8'h00;
    conv_done = 1'b0; model_on = 1'b1; log_n = 0; lat_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R2", "reset busy", busy, 0);
    chk(!conv_req, "R9", "reset request", conv_req, 0);

    // table of modes, masks and start sources (R2 R4 R5 R8)
    for (int v = 0; v < 8; v++) begin
      logic [47:0] e;
      int cnt;
      string tag;
      e = VEC[v];
      cnt = int'(e[35:32]);
      tag = (e[47:46] == 2'd0) ? "R4" : "R5";
      mode = e[47:46];
      chan_mask = e[45:38];
      log_n = 0;
      fire(int'(e[37:36]));
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      if (cnt == 0) begin
        @(negedge clk);
        chk(!busy, "R8", "empty mask clears start", busy, 0);
        chk(!conv_req, "R8", "empty mask no request", conv_req, 0);
      end
      wait_idle();
      chk(log_n == cnt, tag, "conversion count", log_n, cnt);
      for (int j = 0; j < cnt && j < log_n; j++)
        chk(log_ch[j] == e[4*j +: 3], tag, "channel order",
            int'(log_ch[j]), int'(e[4*j +: 3]));
      chk(!busy, tag, "start self-clears", busy, 0);
    end

    // looping scan (R6) then software clear (R3)
    mode = 2'd2; chan_mask = 8'h0A; log_n = 0;
    fire(0);
    for (int k = 0; k < 300 && log_n < 5; k++) @(negedge clk);
    sw_clear();
    chk(!busy, "R3", "software clear", busy, 0);
    wait_idle();
    chk(log_n >= 5 && log_n <= 6, "R6", "loop conversions", log_n, 5);
    for (int j = 0; j < 5; j++)
      chk(log_ch[j] == ((j % 2 == 0) ? 3'd1 : 3'd3), "R6", "loop order",
          int'(log_ch[j]), (j % 2 == 0) ? 1 : 3);
    repeat (10) @(negedge clk);
    chk(!conv_req, "R6", "stopped after clear", conv_req, 0);

    // mode 3 also loops (R6)
    mode = 2'd3; chan_mask = 8'h40; log_n = 0;
    fire(1);
    for (int k = 0; k < 300 && log_n < 3; k++) @(negedge clk);
    chk(busy == 1'b1, "R6", "mode 3 keeps start", busy, 1);
    sw_clear();
    wait_idle();

    // clear during an outstanding conversion (R7, R9)
    model_on = 1'b0; mode = 2'd1; chan_mask = 8'h06; log_n = 0;
    fire(0);
    @(negedge clk);
    chk(conv_req == 1'b1 && conv_ch == 3'd1, "R9", "request channel",
        int'(conv_ch), 1);
    repeat (5) @(negedge clk);
    chk(conv_req == 1'b1 && conv_ch == 3'd1, "R9", "request held",
        int'(conv_ch), 1);
    sw_clear();
    chk(!busy, "R7", "start cleared", busy, 0);
    chk(conv_req == 1'b1, "R7", "request kept", conv_req, 1);
    model_on = 1'b1;
    wait_idle();
    repeat (10) @(negedge clk);
    chk(log_n == 1, "R7", "no new request", log_n, 1);

    // enable gating (R1)
    conv_en = 1'b0; mode = 2'd0; chan_mask = 8'hFF;
    fire(0);
    chk(!busy, "R1", "start ignored with enable low", busy, 0);
    conv_en = 1'b1; model_on = 1'b0; mode = 2'd1;
    fire(2);
    @(negedge clk);
    chk(conv_req == 1'b1, "R1", "request issued", conv_req, 1);
    conv_en = 1'b0;
    @(negedge clk);
    chk(!conv_req, "R1", "request dropped", conv_req, 0);
    chk(!busy, "R1", "start dropped", busy, 0);
    conv_en = 1'b1; model_on = 1'b1;

    // looping scan with empty mask (R8)
    mode = 2'd2; chan_mask = 8'h00; log_n = 0;
    fire(0);
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R8", "looping empty keeps start", busy, 1);
    chk(!conv_req && log_n == 0, "R8", "looping empty no request", log_n, 0);
    sw_clear();
    chk(!busy, "R3", "clear from empty loop", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule